// File: doc/BRIEF.md
# Pulse Accumulator Event Counter

This block counts activity on a single external input pin in an 8-bit register that software can preload. It has two modes. In event mode it adds one for each input edge of the selected polarity. In gated mode it adds one for every 64 system clocks that the input holds at its active level, which makes it a measure of how long a pulse lasted. The pin passes through a two-stage synchroniser before any edge is detected.

Two sticky flags record input activity:

- The edge flag is set on every qualifying input edge, whether or not counting is enabled.
- The overflow flag is set when the count wraps from FFh to 00h.

Each flag has its own mask, and each masked flag drives its own interrupt line. A separate control bit sets the direction of the shared pin. Software reaches the control, status and count registers through a simple byte-wide register port: a 2-bit offset, a write strobe, write data and combinational read data.

Top module: `pulse_acc`

## Requirements
- R1: After reset the control register (offset 0), the status register (offset 1) and the count (offset 2) all read 00h, and `pin_oe`, `irq_edge` and `irq_ovf` are all 0.
- R2: Writing offset 2 loads the count with any value from 00h to FFh, and reading offset 2 returns it. If a load and an increment fall in the same cycle, the loaded value is kept and the increment is lost.
- R3: With control bit 0 (enable) set to 1 and control bit 1 (mode) set to 0, the count advances by exactly one per selected input edge. The edge takes effect three clock edges after the pin changes: two synchroniser stages and one count register.
- R4: Control bit 2 (polarity) selects the counted edge. A value of 1 selects the rising edge and 0 selects the falling edge; the edge of the other polarity is ignored.
- R5: Status bit 0 (edge flag) is set by each selected edge in event mode, even when the enable bit is 0. In gated mode it is set instead by the trailing edge of the gate, which is the end of the active level.
- R6: An increment from FFh sets the count to 00h and sets status bit 1 (overflow flag).
- R7: `irq_edge` is high while the edge flag and control bit 4 are both 1. `irq_ovf` is high while the overflow flag and control bit 5 are both 1.
- R8: `pin_oe` follows control bit 3, and changing that bit does not change the count.
- R9: With enable set and mode set to 1, the count advances once for each complete run of 64 consecutive clocks during which the synchronised input holds its active level. The active level is high when polarity is 1 and low when polarity is 0. The 64-clock phase restarts each time the gate opens.
- R10: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it stays set.
- R11: While the enable bit is 0, input activity never changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 1 | External pulse input; asynchronous to `clk` |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 count |
| reg_wr | input | 1 | Write strobe for `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`; combinational |
| pin_oe | output | 1 | Pin direction: 1 means output |
| irq_edge | output | 1 | Masked edge-flag interrupt request |
| irq_ovf | output | 1 | Masked overflow interrupt request |

## Verification
Event mode is exercised with pulse trains of each polarity. A count of exactly one per pulse shows that the selected edge is counted and the opposite edge is not; a double count would reveal that both edges were taken.

Gated mode is held active for lengths that are not multiples of 64. These runs separate correct truncation from rounding, and from counting that continues after the gate closes. The same runs check that the edge flag stays clear while the gate is open.

Loads and flag clears are placed in the exact cycle of a competing increment or flag set, so the results show which side has priority. A preload of FEh followed by two edges exercises the wrap to 00h and the overflow flag.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       ovf_mask;
    logic       edge_mask;
    logic       pin_dir;
    logic       polarity;
    logic       gated;
    logic       enable;
  } ctrl_t;

  // Next value of a sticky flag: a set in the same cycle beats a clear.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Edge that marks an event: in event mode the selected edge,
  // in gated mode the trailing edge of the active level.
  function automatic logic event_edge(logic pol, logic gated, logic rise, logic fall);
    return (pol ^ gated) ? rise : fall;
  endfunction
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int SH_W = SYNC_STAGES + 1;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], pin};
  end

  assign level = sh[SYNC_STAGES-1];
  assign rise  = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall  = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
endmodule

// File: rtl/pa_gate_tick.sv
module pa_gate_tick #(
  parameter int PRESC_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [PRESC_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (run) phase <= phase + 1'b1;
    else          phase <= '0;
  end

  assign tick = run & (&phase);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] ldata,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap = inc & ~load & (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= ldata;
    else if (inc)  count <= count + 1'b1;
  end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CNT_W       = 8,
  parameter int PRESC_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       pin_oe,
  output logic       irq_edge,
  output logic       irq_ovf
);
  import pa_pkg::*;

  ctrl_t            ctrl;
  logic             flag_edge, flag_ovf;
  logic             s_level, s_rise, s_fall;
  logic             gate_open, gate_tick;
  logic             edge_evt, inc_fire, load_cnt, wrap_evt, wr_ctrl;
  logic             clr_edge, clr_ovf;
  logic [CNT_W-1:0] count;

  pa_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in),
    .level(s_level), .rise(s_rise), .fall(s_fall)
  );

  assign gate_open = ctrl.enable & ctrl.gated & (s_level == ctrl.polarity);

  pa_gate_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(gate_open), .tick(gate_tick)
  );

  assign edge_evt = event_edge(ctrl.polarity, ctrl.gated, s_rise, s_fall);
  assign inc_fire = ctrl.enable & (ctrl.gated ? gate_tick : edge_evt);
  assign load_cnt = reg_wr & (reg_addr == ADDR_COUNT);
  assign wr_ctrl  = reg_wr & (reg_addr == ADDR_CTRL);
  assign clr_edge = reg_wr & (reg_addr == ADDR_STATUS) & reg_wdata[0];
  assign clr_ovf  = reg_wr & (reg_addr == ADDR_STATUS) & reg_wdata[1];

  pa_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc_fire), .load(load_cnt),
    .ldata(reg_wdata[CNT_W-1:0]), .count(count), .wrap(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      flag_edge <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'({2'b00, reg_wdata[5:0]});
      flag_edge <= flag_next(flag_edge, edge_evt, clr_edge);
      flag_ovf  <= flag_next(flag_ovf, wrap_evt, clr_ovf);
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = ctrl;
      ADDR_STATUS: reg_rdata = {6'd0, flag_ovf, flag_edge};
      ADDR_COUNT:  reg_rdata = 8'(count);
      default:     reg_rdata = 8'd0;
    endcase
  end

  assign pin_oe   = ctrl.pin_dir;
  assign irq_edge = flag_edge & ctrl.edge_mask;
  assign irq_ovf  = flag_ovf & ctrl.ovf_mask;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_evt,
  input logic             load_cnt,
  input logic             wrap_evt,
  input logic             wr_ctrl,
  input logic             enable,
  input logic             flag_edge,
  input logic             flag_ovf,
  input logic             pin_oe,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] count
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_cnt |=> count == $past(wdata[CNT_W-1:0]));

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cnt |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  assert_edge_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> flag_edge);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_ovf && (count == '0));

  assert_pin_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> pin_oe == $past(wdata[3]));

  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_cnt) |=> $stable(count));
endmodule

bind pulse_acc pa_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .load_cnt(load_cnt),
  .wrap_evt(wrap_evt), .wr_ctrl(wr_ctrl), .enable(ctrl.enable),
  .flag_edge(flag_edge), .flag_ovf(flag_ovf), .pin_oe(pin_oe),
  .wdata(reg_wdata), .count(count)
);

// File: tb/pulse_acc_tb.sv
`timescale 1ns/1ps
module pulse_acc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       pin_oe, irq_edge, irq_ovf;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  pulse_acc u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_oe(pin_oe), .irq_edge(irq_edge), .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One full pulse away from the idle level and back, 6 clocks per level.
  task automatic pulse(input logic idle_lvl);
    @(negedge clk); pin_in = ~idle_lvl; idle(6);
    pin_in = idle_lvl; idle(6);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 count", d, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 irqs", {irq_edge, irq_ovf}, 0);
  endtask

  task automatic t_load;
    logic [7:0] d;
    wr(2'd2, 8'hA5); rd(2'd2, d); check("R2 load A5", d, 8'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 load FF", d, 8'hFF);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R2 load 00", d, 8'h00);
  endtask

  task automatic t_event_rise;
    logic [7:0] d;
    wr(2'd0, 8'h05); wr(2'd2, 8'h00); wr(2'd1, 8'h03);
    repeat (3) pulse(1'b0);
    rd(2'd2, d); check("R3 R4 rising count", d, 3);
    rd(2'd1, d); check("R5 edge flag event", d[0], 1);
  endtask

  task automatic t_event_fall;
    logic [7:0] d;
    wr(2'd0, 8'h01); wr(2'd2, 8'h00);
    @(negedge clk); pin_in = 1'b1; idle(6);
    rd(2'd2, d); check("R4 rising ignored", d, 0);
    repeat (2) pulse(1'b1);
    rd(2'd2, d); check("R4 falling count", d, 2);
    @(negedge clk); pin_in = 1'b0; idle(6);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(2'd0, 8'h04); wr(2'd2, 8'h33); wr(2'd1, 8'h01);
    rd(2'd1, d); check("R10 edge flag cleared", d[0], 0);
    repeat (2) pulse(1'b0);
    rd(2'd2, d); check("R11 disabled count held", d, 8'h33);
    rd(2'd1, d); check("R5 flag while disabled", d[0], 1);
  endtask

  task automatic t_irq_flags;
    logic [7:0] d;
    wr(2'd0, 8'h04); check("R7 irq_edge masked", irq_edge, 0);
    wr(2'd0, 8'h14); check("R7 irq_edge unmasked", irq_edge, 1);
    wr(2'd1, 8'h00); rd(2'd1, d); check("R10 write 0 keeps flag", d[0], 1);
    wr(2'd1, 8'h01); check("R10 R7 cleared irq_edge", irq_edge, 0);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    wr(2'd0, 8'h25); wr(2'd2, 8'hFE); wr(2'd1, 8'h03);
    pulse(1'b0);
    rd(2'd1, d); check("R6 no ovf at FF", d[1], 0);
    pulse(1'b0);
    rd(2'd2, d); check("R6 wrap to 00", d, 0);
    rd(2'd1, d); check("R6 ovf flag", d[1], 1);
    check("R7 irq_ovf", irq_ovf, 1);
    wr(2'd1, 8'h02);
    rd(2'd1, d); check("R10 ovf cleared", d[1], 0);
    check("R7 irq_ovf low", irq_ovf, 0);
  endtask

  task automatic t_gated;
    logic [7:0] d;
    wr(2'd0, 8'h07); wr(2'd2, 8'h00); wr(2'd1, 8'h03);
    @(negedge clk); pin_in = 1'b1; idle(100);
    rd(2'd1, d); check("R5 no flag mid-gate", d[0], 0);
    idle(99); pin_in = 1'b0; idle(6);
    rd(2'd2, d); check("R9 gated 200 clocks", d, 3);
    rd(2'd1, d); check("R5 trailing edge flag", d[0], 1);
    @(negedge clk); pin_in = 1'b1; idle(63); pin_in = 1'b0; idle(6);
    rd(2'd2, d); check("R9 63 clocks no step", d, 3);
  endtask

  task automatic t_pindir;
    logic [7:0] d;
    wr(2'd2, 8'h5A);
    wr(2'd0, 8'h08); check("R8 pin_oe set", pin_oe, 1);
    rd(2'd2, d); check("R8 count untouched", d, 8'h5A);
    wr(2'd0, 8'h00); check("R8 pin_oe clear", pin_oe, 0);
  endtask

  // Load and flag clear land in the cycle of a competing increment/set.
  task automatic t_priority;
    logic [7:0] d;
    wr(2'd0, 8'h05); wr(2'd2, 8'h10); wr(2'd1, 8'h03);
    @(negedge clk); pin_in = 1'b1;
    idle(2);
    reg_addr = 2'd2; reg_wdata = 8'h40; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd2, d); check("R2 load beats increment", d, 8'h40);
    @(negedge clk); pin_in = 1'b0; idle(6);
    wr(2'd1, 8'h03);
    @(negedge clk); pin_in = 1'b1;
    idle(2);
    reg_addr = 2'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd1, d); check("R10 set beats clear", d[0], 1);
    rd(2'd2, d); check("R3 single step", d, 8'h41);
    @(negedge clk); pin_in = 1'b0; idle(6);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_load();
    t_event_rise();
    t_event_fall();
    t_disabled();
    t_irq_flags();
    t_overflow();
    t_gated();
    t_pindir();
    t_priority();
    finish_run();
  end
endmodule